// File: doc/BRIEF.md
# Histogram Counter Readout Port

This block owns the histogram counter memory and is the host's only way into it. A narrow register bus selects one of four registers. Writing the pointer register picks the counter word where the next readout starts. Each read of the data register returns one counter word and moves the pointer on by one, wrapping at the end of memory. A single control bit selects clear-on-read. While that bit is set, the memory word being returned is zeroed on the same clock edge that captures it. One pass over the memory therefore both drains the statistics and leaves the memory zeroed for the next frame.

The accumulation side shares the memory. It raises a busy flag while a frame is being binned and presents one bin index per increment. Counters saturate at their all-ones value. Data-register reads are held off with a wait response while the engine is busy. The same wait covers the zeroing sweep that runs after every reset. Back-to-back reads are accepted once per clock, so a burst reader can stream the memory at full rate.

Register select codes: 0 = control (bit 0 is clear-on-read, other bits read as zero), 1 = read pointer, 2 = data, 3 = reserved (reads zero, writes ignored).

Top module: `hist_readout_port`

## Requirements
- R1: Reset forces the read pointer to 0 and the clear-on-read bit to 0. After reset releases, an internal sweep zeroes every counter word, one word per clock. `bus_wait` is high for exactly MEM_WORDS cycles after the release (with the engine idle), and every word then reads 0.
- R2: An accepted read of any register (select 0, 1, 2 or 3) raises `bus_rvalid` on the following cycle, with the value in `bus_rdata`. Counter words are zero-extended to 32 bits.
- R3: Each accepted data read (select 2) advances the pointer by one, and the pointer wraps from MEM_WORDS-1 to 0.
- R4: Writing select 1 loads the pointer from the low log2(MEM_WORDS) bits of `bus_wdata` and ignores the upper bits. Reading select 1 returns the pointer zero-extended.
- R5: With control bit 0 set, the word returned by a data read is zeroed in memory on the same edge that captures it. With the bit clear, reads leave memory unchanged.
- R6: With clear-on-read set, MEM_WORDS consecutive data reads starting at pointer 0 leave every counter word at zero.
- R7: While `eng_busy` is high or the reset sweep runs, `bus_wait` is high. A data read issued then is not accepted: no `bus_rvalid` follows and the pointer does not move.
- R8: An increment on `eng_inc` adds one to word `eng_bin` only while `eng_busy` is high and the sweep is finished. Otherwise it has no effect.
- R9: Data reads held on consecutive cycles are accepted every cycle and return consecutive words.
- R10: Writes to select 2 or 3 change no state. Control bits other than bit 0 read back as zero.
- R11: A counter at its all-ones value stays there on further increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| bus_wait | output | 1 | Data reads are held off this cycle |
| eng_busy | input | 1 | Accumulation engine owns the memory |
| eng_inc | input | 1 | Increment request |
| eng_bin | input | log2(MEM_WORDS) | Counter word to increment |

## Verification
The bench builds the port with MEM_WORDS = 16 and CNT_W = 4. With a sixteen-word memory, the reset sweep, full clear-on-read passes and pointer wraparound all finish within a few dozen cycles. With four-bit counters, saturation at 15 is reached after a handful of increments. Wait-state reads during a busy frame, increments offered while idle, and writes to the data register are all exercised against the behavioural model.

// File: rtl/hist_port_pkg.sv
package hist_port_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_PTR  = 2'd1,
        REG_DATA = 2'd2,
        REG_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              req;
        logic              write;
        reg_sel_e          sel;
        logic [WORD_W-1:0] wdata;
    } bus_cmd_t;

    // Increment that stops at the all-ones code
    function automatic logic [WORD_W-1:0] sat_inc(input logic [WORD_W-1:0] v,
                                                  input logic [WORD_W-1:0] top);
        return (v == top) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/hist_clear_sweep.sv
module hist_clear_sweep #(
    parameter int MEM_WORDS = 256,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          sweep_on,
    output logic [AW-1:0] sweep_idx
);
    localparam logic [AW-1:0] LAST = AW'(MEM_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sweep_on  <= 1'b1;
            sweep_idx <= '0;
        end else if (sweep_on) begin
            if (sweep_idx == LAST) begin
                sweep_on <= 1'b0;
            end else begin
                sweep_idx <= sweep_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hist_counter_mem.sv
module hist_counter_mem
    import hist_port_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int CNT_W = 32,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic             clk,
    input  logic             sweep_on,
    input  logic [AW-1:0]    sweep_idx,
    input  logic             rd_go,
    input  logic             rd_clr,
    input  logic [AW-1:0]    rd_idx,
    input  logic             inc_go,
    input  logic [AW-1:0]    inc_idx,
    output logic [CNT_W-1:0] rd_word
);
    localparam logic [WORD_W-1:0] CNT_TOP = WORD_W'({CNT_W{1'b1}});

    logic [MEM_WORDS-1:0][CNT_W-1:0] cnt_flat;

    for (genvar g = 0; g < MEM_WORDS; g++) begin : g_word
        logic [CNT_W-1:0] word_q;
        logic             hit_sweep;
        logic             hit_clr;
        logic             hit_inc;

        always_comb begin
            hit_sweep = sweep_on && (sweep_idx == AW'(g));
            hit_clr   = rd_go && rd_clr && (rd_idx == AW'(g));
            hit_inc   = inc_go && (inc_idx == AW'(g));
        end

        // Sweep wins over clear-on-read, which wins over increment
        always_ff @(posedge clk) begin
            if (hit_sweep || hit_clr) begin
                word_q <= '0;
            end else if (hit_inc) begin
                word_q <= CNT_W'(sat_inc(WORD_W'(word_q), CNT_TOP));
            end
        end

        assign cnt_flat[g] = word_q;
    end

    assign rd_word = cnt_flat[rd_idx];
endmodule

// File: rtl/hist_host_regs.sv
module hist_host_regs
    import hist_port_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int CNT_W = 32,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  logic              mem_wait,
    input  logic [CNT_W-1:0]  mem_word,
    output logic              rd_go,
    output logic [AW-1:0]     ptr_q,
    output logic              clr_q,
    output logic [WORD_W-1:0] rdata_q,
    output logic              rvalid_q
);
    localparam logic [AW-1:0] LAST = AW'(MEM_WORDS - 1);

    logic              rd_any;
    logic              rd_accept;
    logic              wr_any;
    logic [WORD_W-1:0] rd_mux;
    logic              unused_wbits;

    assign unused_wbits = ^cmd.wdata;

    always_comb begin
        rd_any    = cmd.req && !cmd.write;
        wr_any    = cmd.req && cmd.write;
        rd_go     = rd_any && (cmd.sel == REG_DATA) && !mem_wait;
        rd_accept = rd_any && ((cmd.sel != REG_DATA) || !mem_wait);
        unique case (cmd.sel)
            REG_CTRL: rd_mux = WORD_W'(clr_q);
            REG_PTR:  rd_mux = WORD_W'(ptr_q);
            REG_DATA: rd_mux = WORD_W'(mem_word);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            clr_q    <= 1'b0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_accept;
            if (rd_accept) begin
                rdata_q <= rd_mux;
            end
            if (wr_any) begin
                unique case (cmd.sel)
                    REG_CTRL: clr_q <= cmd.wdata[0];
                    REG_PTR:  ptr_q <= cmd.wdata[AW-1:0];
                    default:  ;
                endcase
            end else if (rd_go) begin
                ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hist_readout_port.sv
module hist_readout_port
    import hist_port_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int CNT_W = 32,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_req,
    input  logic          bus_write,
    input  logic [1:0]    bus_reg,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_rvalid,
    output logic          bus_wait,
    input  logic          eng_busy,
    input  logic          eng_inc,
    input  logic [AW-1:0] eng_bin
);
    bus_cmd_t         cmd;
    logic             sweep_on;
    logic [AW-1:0]    sweep_idx;
    logic             rd_go;
    logic [AW-1:0]    ptr_q;
    logic             clr_q;
    logic [CNT_W-1:0] mem_word;
    logic             inc_go;

    always_comb begin
        cmd.req   = bus_req;
        cmd.write = bus_write;
        cmd.sel   = reg_sel_e'(bus_reg);
        cmd.wdata = bus_wdata;
        bus_wait  = sweep_on || eng_busy;
        inc_go    = eng_inc && eng_busy && !sweep_on;
    end

    hist_clear_sweep #(.MEM_WORDS(MEM_WORDS)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .sweep_on  (sweep_on),
        .sweep_idx (sweep_idx)
    );

    hist_host_regs #(.MEM_WORDS(MEM_WORDS), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .mem_wait (bus_wait),
        .mem_word (mem_word),
        .rd_go    (rd_go),
        .ptr_q    (ptr_q),
        .clr_q    (clr_q),
        .rdata_q  (bus_rdata),
        .rvalid_q (bus_rvalid)
    );

    hist_counter_mem #(.MEM_WORDS(MEM_WORDS), .CNT_W(CNT_W)) u_mem (
        .clk       (clk),
        .sweep_on  (sweep_on),
        .sweep_idx (sweep_idx),
        .rd_go     (rd_go),
        .rd_clr    (clr_q),
        .rd_idx    (ptr_q),
        .inc_go    (inc_go),
        .inc_idx   (eng_bin),
        .rd_word   (mem_word)
    );
endmodule

// File: rtl/hist_readout_port_chk.sv
module hist_readout_port_chk #(
    parameter int MEM_WORDS = 256,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_write,
    input logic [1:0]    bus_reg,
    input logic [31:0]   bus_wdata,
    input logic          bus_rvalid,
    input logic          bus_wait,
    input logic [AW-1:0] ptr_q,
    input logic          clr_q
);
    logic data_try;
    assign data_try = bus_req && !bus_write && (bus_reg == 2'd2);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ptr_q == '0) && !clr_q && bus_wait);

    // R2
    data_read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (data_try && !bus_wait) |=> bus_rvalid);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (data_try && !bus_wait) |=>
        (ptr_q == (($past(ptr_q) == AW'(MEM_WORDS - 1)) ? '0 : $past(ptr_q) + 1'b1)));

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_write && (bus_reg == 2'd1)) |=> (ptr_q == $past(bus_wdata[AW-1:0])));

    // R7
    stall_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
        (data_try && bus_wait) |=> (!bus_rvalid && $stable(ptr_q)));

    // R10
    data_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_write && (bus_reg[1] == 1'b1)) |=> ($stable(ptr_q) && $stable(clr_q)));
endmodule

bind hist_readout_port hist_readout_port_chk #(.MEM_WORDS(MEM_WORDS), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_write  (bus_write),
    .bus_reg    (bus_reg),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_wait   (bus_wait),
    .ptr_q      (ptr_q),
    .clr_q      (clr_q)
);

// File: tb/tb_hist_readout_port.sv
`timescale 1ns/1ps
module tb_hist_readout_port;
    localparam int N    = 16;
    localparam int CW   = 4;
    localparam int AW   = 4;
    localparam int MAXC = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0;
    logic          bus_write = 1'b0;
    logic [1:0]    bus_reg = 2'd0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          bus_wait;
    logic          eng_busy = 1'b0;
    logic          eng_inc = 1'b0;
    logic [AW-1:0] eng_bin = '0;

    always #4 clk = ~clk;

    hist_readout_port #(.MEM_WORDS(N), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_write(bus_write),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_wait(bus_wait), .eng_busy(eng_busy),
        .eng_inc(eng_inc), .eng_bin(eng_bin)
    );

    int    tests = 0;
    int    fails = 0;
    string cur = "R1";
    bit    done = 0;

    // Behavioural reference state
    int mm[N];
    int m_ptr = 0;
    int m_clr = 0;
    int m_sweep = 0;
    bit ev = 0;
    int er = 0;
    bit armed = 0;

    int last_rd = 0;
    int nz = 0;
    bit nz_en = 0;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit wv;
        if (rst) begin
            m_ptr = 0; m_clr = 0; m_sweep = N; ev = 0;
        end else begin
            wv = (m_sweep > 0) || eng_busy;
            ev = 0;
            if (bus_req) begin
                if (bus_write) begin
                    if (bus_reg == 2'd0) m_clr = bus_wdata[0];
                    else if (bus_reg == 2'd1) m_ptr = bus_wdata % N;
                end else begin
                    case (bus_reg)
                        2'd0: begin ev = 1; er = m_clr; end
                        2'd1: begin ev = 1; er = m_ptr; end
                        2'd2: if (!wv) begin
                            ev = 1; er = mm[m_ptr];
                            if (m_clr != 0) mm[m_ptr] = 0;
                            m_ptr = (m_ptr + 1) % N;
                        end
                        default: begin ev = 1; er = 0; end
                    endcase
                end
            end
            if (eng_inc && eng_busy && m_sweep == 0 && mm[eng_bin] < MAXC)
                mm[eng_bin] = mm[eng_bin] + 1;
            if (m_sweep > 0) begin
                mm[N - m_sweep] = 0;
                m_sweep = m_sweep - 1;
            end
        end
        armed = 1;
    end

    always @(posedge clk) begin
        #3;
        if (armed) begin
            chk({cur, " rvalid"}, int'(bus_rvalid), int'(ev));
            if (ev) chk({cur, " rdata"}, int'(bus_rdata), er);
            chk({cur, " wait"}, int'(bus_wait), int'((m_sweep > 0) || eng_busy));
            if (bus_rvalid) begin
                last_rd = int'(bus_rdata);
                if (nz_en && bus_rdata != 0) nz++;
            end
        end
    end

    task automatic wr_reg(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_write = 1; bus_reg = s; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_write = 0;
    endtask

    task automatic rd_burst(logic [1:0] s, int k);
        @(negedge clk);
        bus_req = 1; bus_write = 0; bus_reg = s;
        repeat (k) @(negedge clk);
        bus_req = 0;
    endtask

    task automatic bump(int bin, int k);
        @(negedge clk);
        eng_inc = 1; eng_bin = AW'(bin);
        repeat (k) @(negedge clk);
        eng_inc = 0;
    endtask

    task automatic wait_sweep(string tag);
        int n = 0;
        while (bus_wait) begin
            @(negedge clk);
            n++;
        end
        chk(tag, n, N);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired in %s", cur);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        wait_sweep("R1 sweep length");
        rd_burst(2'd0, 1); chk("R1 clear bit after reset", last_rd, 0);
        rd_burst(2'd1, 1); chk("R1 pointer after reset", last_rd, 0);

        cur = "R8 busy increments";
        @(negedge clk) eng_busy = 1;
        bump(3, 2); bump(5, 20); bump(15, 1); bump(0, 4);
        cur = "R7 stalled read";
        rd_burst(2'd2, 3);
        @(negedge clk) eng_busy = 0;
        rd_burst(2'd1, 1); chk("R7 pointer held", last_rd, 0);
        cur = "R8 idle increments";
        bump(7, 3);

        cur = "R2 R9 burst";
        wr_reg(2'd0, 0); wr_reg(2'd1, 0);
        rd_burst(2'd2, 8);
        chk("R9 eighth word", last_rd, 0);
        wr_reg(2'd1, 5); rd_burst(2'd2, 1); chk("R11 saturated word", last_rd, MAXC);
        wr_reg(2'd1, 7); rd_burst(2'd2, 1); chk("R8 idle bump ignored", last_rd, 0);
        wr_reg(2'd1, 3); rd_burst(2'd2, 1); chk("R2 word 3", last_rd, 2);

        cur = "R3 wrap";
        wr_reg(2'd1, 14); rd_burst(2'd2, 4);
        chk("R3 word 1 after wrap", last_rd, 0);
        rd_burst(2'd1, 1); chk("R3 pointer after wrap", last_rd, 2);

        cur = "R4 pointer";
        wr_reg(2'd1, 9); rd_burst(2'd1, 1); chk("R4 pointer load", last_rd, 9);
        wr_reg(2'd1, 32'hFFFF_FFF3); rd_burst(2'd1, 1); chk("R4 upper bits ignored", last_rd, 3);

        cur = "R5 clear on read";
        wr_reg(2'd0, 1); rd_burst(2'd2, 1); chk("R5 first read", last_rd, 2);
        wr_reg(2'd1, 3); rd_burst(2'd2, 1); chk("R5 word zeroed", last_rd, 0);
        wr_reg(2'd0, 0); wr_reg(2'd1, 0); rd_burst(2'd2, 1); chk("R5 plain read", last_rd, 4);
        wr_reg(2'd1, 0); rd_burst(2'd2, 1); chk("R5 word kept", last_rd, 4);

        cur = "R6 full drain";
        @(negedge clk) eng_busy = 1;
        bump(9, 3); bump(12, 1);
        @(negedge clk) eng_busy = 0;
        wr_reg(2'd0, 1); wr_reg(2'd1, 0);
        rd_burst(2'd2, N);
        wr_reg(2'd0, 0);
        nz = 0; nz_en = 1;
        rd_burst(2'd2, N);
        nz_en = 0;
        chk("R6 nonzero words after drain", nz, 0);

        cur = "R10 inert writes";
        wr_reg(2'd0, 32'hFFFF_FFFF); rd_burst(2'd0, 1); chk("R10 control readback", last_rd, 1);
        rd_burst(2'd3, 1); chk("R10 reserved reads zero", last_rd, 0);
        wr_reg(2'd0, 0);
        @(negedge clk) eng_busy = 1;
        bump(2, 5);
        @(negedge clk) eng_busy = 0;
        wr_reg(2'd1, 2); wr_reg(2'd2, 0); wr_reg(2'd3, 32'h5);
        rd_burst(2'd1, 1); chk("R10 pointer unchanged", last_rd, 2);
        rd_burst(2'd2, 1); chk("R10 word unchanged", last_rd, 5);

        cur = "R1 second reset";
        @(negedge clk) eng_busy = 1;
        bump(1, 6);
        @(negedge clk) eng_busy = 0;
        @(negedge clk) rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        wait_sweep("R1 second sweep length");
        wr_reg(2'd1, 1); rd_burst(2'd2, 1); chk("R1 memory zeroed", last_rd, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule